// File: doc/BRIEF.md
# Two-Word Branch Program Counter Unit

This block keeps the program counter of a small 4-bit controller and carries out its branch instructions. Program memory is word addressed with 10-bit words. It is split into 1K-word pages, and a page bit sits above the 10-bit in-page counter. Each `step` strobe retires one instruction. An ordinary instruction moves the counter on by one word. A branch takes two words: the first word holds the operation and the destination page, and the second word holds a 10-bit target whose bits are stored in a shuffled order.

When a step decodes a branch, the unit samples the carry and status flags in that same cycle. In the next cycle it presents the address of the second word, captures that word and then updates the counter. A branch that is taken loads the un-shuffled target and the page from the opcode. A branch that is not taken skips both words. Counter arithmetic wraps inside the current page.

The unit is built for one or two pages of memory. In the one-page build, a branch that names page 1 is reported on a one-cycle illegal-opcode pulse, and the page bit stays at 0.

Top module: `pcu_branch_unit`

## Requirements
- R1: While reset is applied and after it is released, `fetch_addr` is 0 (page 0, offset 000H) and `illegal_op` is 0. Release takes effect two clock edges after `rst_n` rises.
- R2: A step whose first word is not a branch moves `fetch_addr` forward by one word. This includes a word with the branch low bits but an unlisted high field, and a listed high field with wrong low bits. Without a step, `fetch_addr` holds.
- R3: Every +1 and +2 advance wraps from 3FFH to 000H inside the current page. The page bit (`fetch_addr[10]`) changes only on a taken branch.
- R4: A word is a branch when its bits [4:0] are 10001. Its bits [9:5] then select the operation as follows, page 0 / page 1: jump 01000/01001; jump if carry set 01100/01010; jump if carry clear 01101/01011; jump if status set 01110/10000; jump if status clear 01111/10001.
- R5: The second word stores the target, from bit 9 down to bit 0, as a9, a7, a6, a5, a4, a8, a3, a2, a1, a0. The unit loads the target as a9..a0.
- R6: An unconditional jump loads the 10-bit target and the page given by its opcode.
- R7: A conditional branch is taken only when its condition holds: carry is 1, carry is 0, status is 1 or status is 0, depending on the operation.
- R8: A conditional branch that is not taken sets the offset to the first word's address + 2 and keeps the page.
- R9: The flags are sampled in the cycle that decodes the first word. Flag changes during the address-word cycle have no effect.
- R10: In the cycle after a branch is decoded, `fetch_addr` points at the first word + 1. A step in that cycle is ignored. The new counter appears in the following cycle.
- R11: When `MEM_PAGES` is 1, a page-1 branch raises `illegal_op` for exactly the address-word cycle, and the page bit stays 0. The branch still resolves within page 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| step | input | 1 | Retire the instruction at `fetch_addr` |
| instr_word | input | 10 | Program memory word read at `fetch_addr` |
| carry_flag | input | 1 | Carry flag |
| status_flag | input | 1 | Status flag |
| fetch_addr | output | 11 | {page, 10-bit offset} of the word to fetch |
| illegal_op | output | 1 | Page-1 branch in a one-page build |

## Verification
The bench places branches at 3FEH so that a skip crosses the page end. A design that carries into the page bit there would land in page 1 instead of at offset 000H. Targets are chosen so that a8 and a9 differ, which catches a missing or wrong un-shuffle of the address word. All four conditional branches run with both flag values and in both pages. During the address-word cycle the bench flips the flags and holds `step` high, so a design that reads the flags late or steps twice ends up at the wrong address. A one-page instance must raise the illegal pulse for a page-1 branch while the page bit stays 0.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int WORD_W = 10;
  localparam int OPC_W  = 5;
  localparam logic [OPC_W-1:0] BR_TAG = 5'b10001;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_JMP,
    OP_JC,
    OP_JNC,
    OP_JF,
    OP_JNF
  } br_op_e;

  typedef struct packed {
    logic   hit;
    br_op_e op;
    logic   page;
  } br_dec_t;
endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
  import pcu_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output br_dec_t           dec
);
  always_comb begin
    dec.hit  = 1'b0;
    dec.op   = OP_NONE;
    dec.page = 1'b0;
    if (word[OPC_W-1:0] == BR_TAG) begin
      dec.hit = 1'b1;
      case (word[WORD_W-1:OPC_W])
        5'b01000: dec.op = OP_JMP;
        5'b01001: begin dec.op = OP_JMP; dec.page = 1'b1; end
        5'b01100: dec.op = OP_JC;
        5'b01010: begin dec.op = OP_JC;  dec.page = 1'b1; end
        5'b01101: dec.op = OP_JNC;
        5'b01011: begin dec.op = OP_JNC; dec.page = 1'b1; end
        5'b01110: dec.op = OP_JF;
        5'b10000: begin dec.op = OP_JF;  dec.page = 1'b1; end
        5'b01111: dec.op = OP_JNF;
        5'b10001: begin dec.op = OP_JNF; dec.page = 1'b1; end
        default:  dec.hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pcu_cond.sv
module pcu_cond
  import pcu_pkg::*;
(
  input  br_op_e op,
  input  logic   carry,
  input  logic   status,
  output logic   taken
);
  always_comb begin
    case (op)
      OP_JMP:  taken = 1'b1;
      OP_JC:   taken = carry;
      OP_JNC:  taken = ~carry;
      OP_JF:   taken = status;
      OP_JNF:  taken = ~status;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcu_unperm.sv
module pcu_unperm
  import pcu_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] addr
);
  localparam int LOW_W = OPC_W - 1;           // a3..a0 kept in place
  localparam int MID_W = WORD_W - OPC_W - 1;  // a7..a4 shifted down

  genvar gi;
  generate
    for (gi = 0; gi < LOW_W; gi++) begin : g_low
      assign addr[gi] = word[gi];
    end
    for (gi = 0; gi < MID_W; gi++) begin : g_mid
      assign addr[LOW_W + gi] = word[OPC_W + gi];
    end
  endgenerate

  assign addr[WORD_W-2] = word[LOW_W];
  assign addr[WORD_W-1] = word[WORD_W-1];
endmodule

// File: rtl/pcu_branch_unit.sv
module pcu_branch_unit
  import pcu_pkg::*;
#(
  parameter int MEM_PAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [WORD_W-1:0] instr_word,
  input  logic              carry_flag,
  input  logic              status_flag,
  output logic [WORD_W:0]   fetch_addr,
  output logic              illegal_op
);
  localparam bit HAS_PAGE1 = (MEM_PAGES > 1);

  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [WORD_W-1:0] pc_q, pc_d;
  logic              page_q, page_d;
  logic              busy_q, busy_d;
  logic              taken_q, taken_d;
  logic              tpage_q, tpage_d;
  logic              illegal_q, illegal_d;

  br_dec_t           dec;
  logic              cond_taken;
  logic [WORD_W-1:0] target;
  logic [WORD_W-1:0] pc_inc1, pc_inc2;

  pcu_decode u_decode (.word(instr_word), .dec(dec));

  pcu_cond u_cond (
    .op     (dec.op),
    .carry  (carry_flag),
    .status (status_flag),
    .taken  (cond_taken)
  );

  pcu_unperm u_unperm (.word(instr_word), .addr(target));

  assign pc_inc1 = pc_q + WORD_W'(1);
  assign pc_inc2 = pc_q + WORD_W'(2);

  always_comb begin
    pc_d      = pc_q;
    page_d    = page_q;
    busy_d    = busy_q;
    taken_d   = taken_q;
    tpage_d   = tpage_q;
    illegal_d = 1'b0;
    if (busy_q) begin
      busy_d = 1'b0;
      if (taken_q) begin
        pc_d   = target;
        page_d = tpage_q;
      end else begin
        pc_d   = pc_inc2;
      end
    end else if (step) begin
      if (dec.hit) begin
        busy_d  = 1'b1;
        taken_d = cond_taken;
        if (dec.page && !HAS_PAGE1) begin
          illegal_d = 1'b1;
          tpage_d   = page_q;
        end else begin
          tpage_d   = dec.page;
        end
      end else begin
        pc_d = pc_inc1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q      <= '0;
      page_q    <= 1'b0;
      busy_q    <= 1'b0;
      taken_q   <= 1'b0;
      tpage_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      pc_q      <= pc_d;
      page_q    <= page_d;
      busy_q    <= busy_d;
      taken_q   <= taken_d;
      tpage_q   <= tpage_d;
      illegal_q <= illegal_d;
    end
  end

  assign fetch_addr = busy_q ? {page_q, pc_inc1} : {page_q, pc_q};
  assign illegal_op = illegal_q;
endmodule

// File: rtl/pcu_branch_unit_chk.sv
module pcu_branch_unit_chk
  import pcu_pkg::*;
#(
  parameter int MEM_PAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step,
  input logic              busy,
  input logic [WORD_W:0]   fetch_addr,
  input logic              illegal_op
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_R1: assert (fetch_addr == '0 && !illegal_op)
        else $error("reset state wrong");
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !step) |=> $stable(fetch_addr));

  // R2 and R10: both a plain step and the address-word cycle show offset + 1
  assert_step_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && step) |=> fetch_addr ==
      {$past(fetch_addr[WORD_W]), $past(fetch_addr[WORD_W-1:0]) + 1'b1});

  assert_page_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> fetch_addr[WORD_W] == $past(fetch_addr[WORD_W]));

  assert_addr_phase_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  assert_illegal_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> busy ##1 !illegal_op);

  generate
    if (MEM_PAGES < 2) begin : g_one_page
      assert_no_page1_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_addr[WORD_W]);
    end else begin : g_two_page
      assert_never_illegal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !illegal_op);
    end
  endgenerate
endmodule

bind pcu_branch_unit pcu_branch_unit_chk #(.MEM_PAGES(MEM_PAGES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .step       (step),
  .busy       (busy_q),
  .fetch_addr (fetch_addr),
  .illegal_op (illegal_op)
);

// File: tb/tb_pcu_branch_unit.sv
module tb_pcu_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic        cy = 1'b0;
  logic        sf = 1'b0;
  logic [9:0]  mem2 [0:2047];
  logic [9:0]  mem1 [0:1023];
  logic [10:0] fa2, fa1;
  logic [9:0]  iw2, iw1;
  logic        ill2, ill1;
  int          total = 0;
  int          bad = 0;

  always #10 clk = ~clk;

  assign iw2 = mem2[fa2];
  assign iw1 = mem1[fa1[9:0]];

  pcu_branch_unit #(.MEM_PAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .step(step), .instr_word(iw2),
    .carry_flag(cy), .status_flag(sf), .fetch_addr(fa2), .illegal_op(ill2)
  );

  pcu_branch_unit #(.MEM_PAGES(1)) dut_1k (
    .clk(clk), .rst_n(rst_n), .step(step), .instr_word(iw1),
    .carry_flag(cy), .status_flag(sf), .fetch_addr(fa1), .illegal_op(ill1)
  );

  function automatic logic [9:0] first(input logic [4:0] hi);
    return {hi, 5'b10001};
  endfunction

  function automatic logic [9:0] aword(input logic [9:0] a);
    return {a[9], a[7], a[6], a[5], a[4], a[8], a[3], a[2], a[1], a[0]};
  endfunction

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    for (int i = 0; i < 2048; i++) mem2[i] = 10'h000;
    for (int i = 0; i < 1024; i++) mem1[i] = 10'h000;
    cy = 1'b0; sf = 1'b0; step = 1'b0;
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse();
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  // drive an unconditional jump at the current offset of the two-page unit
  task automatic jump2(input logic page, input logic [9:0] tgt);
    mem2[fa2] = first(page ? 5'b01001 : 5'b01000);
    mem2[{fa2[10], fa2[9:0] + 10'd1}] = aword(tgt);
    pulse();
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 addr", fa2, 11'h000);
    check("R1 illegal", {10'd0, ill2}, 11'h000);
    pulse();
    check("R2 nop step", fa2, 11'h001);
    repeat (3) @(negedge clk);
    check("R2 hold", fa2, 11'h001);
  endtask

  task automatic t_unknown();
    do_reset();
    mem2[0] = {5'b00000, 5'b10001};
    mem2[1] = {5'b01000, 5'b10000};
    pulse();
    check("R4 unlisted high", fa2, 11'h001);
    pulse();
    check("R4 bad low bits", fa2, 11'h002);
  endtask

  task automatic t_jump();
    do_reset();
    mem2[0] = first(5'b01000);
    mem2[1] = aword(10'h2A5);
    pulse();
    check("R10 address fetch", fa2, 11'h001);
    @(negedge clk);
    check("R5 R6 jump a9 set", fa2, 11'h2A5);
    jump2(1'b0, 10'h150);
    check("R5 jump a8 set", fa2, 11'h150);
  endtask

  task automatic t_page();
    do_reset();
    jump2(1'b1, 10'h3FF);
    check("R6 page1 jump", fa2, {1'b1, 10'h3FF});
    pulse();
    check("R3 wrap +1", fa2, {1'b1, 10'h000});
    jump2(1'b0, 10'h010);
    check("R6 back to page0", fa2, 11'h010);
  endtask

  task automatic t_cond();
    logic [4:0] codes [0:7];
    codes[0] = 5'b01100; codes[1] = 5'b01101; codes[2] = 5'b01110; codes[3] = 5'b01111;
    codes[4] = 5'b01010; codes[5] = 5'b01011; codes[6] = 5'b10000; codes[7] = 5'b10001;
    for (int k = 0; k < 8; k++) begin
      for (int v = 0; v < 2; v++) begin
        logic tk;
        logic [10:0] exp;
        do_reset();
        mem2[0] = first(codes[k]);
        mem2[1] = aword(10'h123);
        cy = (k % 4 < 2) ? v[0] : ~v[0];
        sf = (k % 4 < 2) ? ~v[0] : v[0];
        case (k % 4)
          0: tk = cy;
          1: tk = ~cy;
          2: tk = sf;
          default: tk = ~sf;
        endcase
        exp = tk ? {(k >= 4), 10'h123} : 11'h002;
        pulse();
        cy = ~cy;
        sf = ~sf;
        @(negedge clk);
        if (tk) check("R7 R9 taken", fa2, exp);
        else    check("R8 R9 not taken", fa2, exp);
      end
    end
  endtask

  task automatic t_skip_wrap();
    do_reset();
    jump2(1'b1, 10'h3FE);
    mem2[{1'b1, 10'h3FE}] = first(5'b01010);
    mem2[{1'b1, 10'h3FF}] = aword(10'h0AA);
    cy = 1'b0;
    pulse();
    @(negedge clk);
    check("R3 R8 skip wraps in page", fa2, {1'b1, 10'h000});
  endtask

  task automatic t_busy_step();
    do_reset();
    mem2[0] = first(5'b01000);
    mem2[1] = aword(10'h040);
    step = 1'b1;
    repeat (2) @(negedge clk);
    step = 1'b0;
    check("R10 step ignored in address cycle", fa2, 11'h040);
    @(negedge clk);
    check("R10 settled", fa2, 11'h040);
  endtask

  task automatic t_one_page();
    do_reset();
    mem1[0] = first(5'b01001);
    mem1[1] = aword(10'h055);
    pulse();
    check("R11 illegal raised", {10'd0, ill1}, 11'h001);
    check("R11 address fetch", fa1, 11'h001);
    @(negedge clk);
    check("R11 page kept 0", fa1, 11'h055);
    check("R11 illegal cleared", {10'd0, ill1}, 11'h000);
    mem1[10'h055] = first(5'b01010);
    mem1[10'h056] = aword(10'h300);
    cy = 1'b1;
    pulse();
    @(negedge clk);
    check("R11 page1 branch stays page0", fa1, 11'h300);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_unknown();
    t_jump();
    t_page();
    t_cond();
    t_skip_wrap();
    t_busy_step();
    t_one_page();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule